// File: doc/BRIEF.md
# Timed-Sequence Sleep Power Controller

This block is the power-management register slice of a small microcontroller. It stores a sleep-enable bit and a two-bit sleep-mode field in a power control register. A second register holds a protected request to switch the brown-out detector off during the next sleep. Software can only set that request with two writes that follow each other closely. The first write opens a short unlock window, and the second write arms the request. An armed request becomes usable after a fixed delay and then withdraws itself a few cycles later.

The processor core signals its sleep instruction with a one-cycle strobe. If sleep is enabled, the block enters the sleep state. It decides whether the brown-out detector stays on, and whether the digital input buffers are turned off, from the guard state and the mode selected at that moment. A wake event ends the sleep state, and everything returns to the awake values on the next clock edge. Software reads and writes the two registers through a plain address/data port with a write strobe. Reads are combinational.

Top module: `sleep_power_ctrl`

## Requirements
- R1: After synchronous active-low reset, both registers read zero, `sleep_active` and `inbuf_disable` are 0, and `bod_enable` is 1.
- R2: Address 0 is the guard register. Bit 1 reads the armed flag, bit 0 reads the unlock flag, and bits 7:2 read 0. Address 1 is the power register. Bit 5 is sleep enable, bits 4:3 are the mode, and the other bits read 0.
- R3: Writing bits 1:0 = 11 to address 0 sets the unlock flag. The flag stays at 1 for four cycles (after the write edge and the three edges that follow), then clears by itself.
- R4: Writing bits 1:0 = 10 to address 0 on any of the four edges after the unlock write sets the armed flag. The same write on the fifth edge or later, or with no unlock before it, leaves the armed flag at 0.
- R5: Any write to address 0 other than the pattern 11 clears the unlock flag at once. A write with bits 1:0 = 01 or 00 never sets the armed flag.
- R6: The armed flag reads 1 for six cycles, counted from the arming edge, then clears without a write. The guard is live only during the last three of those cycles: a sleep strobe on the 4th, 5th or 6th edge after the arming edge.
- R7: A sleep strobe with sleep enable = 1 sets `sleep_active` on that edge. With sleep enable = 0 the strobe has no effect.
- R8: On sleep entry, `bod_enable` goes to 0 only if the guard is live on the entry edge. Otherwise it stays at 1 for the whole sleep.
- R9: On sleep entry, `inbuf_disable` goes to 1 only if the mode is 10 (power-down). Modes 00 (idle), 01 (ADC noise reduction) and 11 (reserved, treated as idle) keep it at 0.
- R10: A wake event returns all three outputs to the awake values on the next edge. A wake and a sleep strobe on the same edge leave the block awake.
- R11: While asleep, further sleep strobes and register writes do not change `bod_enable` or `inbuf_disable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 guard, 1 power |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| sleep_strobe | input | 1 | One-cycle sleep instruction pulse |
| wake | input | 1 | Wake event |
| sleep_active | output | 1 | Block is in the sleep state |
| bod_enable | output | 1 | Brown-out detector enable |
| inbuf_disable | output | 1 | Digital input buffers turned off |

## Verification
A wrong unlock-window count shows up at the guard register readback within one cycle of the write that should have been accepted or refused. A later effect is an armed flag that appears where none should. An off-by-one error in the delay or hold counter shows up only through `bod_enable` after a sleep strobe placed on a boundary edge. For that reason, strobes are swept across the edges just before, at and after both ends of the live window. A latched sleep decision that leaks shows up as a change in `bod_enable` or `inbuf_disable` during sleep, or as a value that lasts past the edge after wake.

// File: rtl/slpctl_pkg.sv
// Shared types for the sleep power controller.
// Assumes a two-bit sleep-mode field whose encoding is fixed by software.
package slpctl_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCNR = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_RSVD  = 2'b11
    } slp_mode_e;
endpackage

// File: rtl/bod_guard.sv
// Brown-out guard sequencer.
// Opens an unlock window on an 11 write, arms on a 10 write inside the window,
// then runs a countdown: a delay phase, followed by a live phase.
// Assumes wr_en marks a write aimed at the guard register only.
module bod_guard #(
    parameter int WIN  = 4,
    parameter int DLY  = 3,
    parameter int HOLD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wbits,
    output logic       unlock_open,
    output logic       arm_set,
    output logic       arm_live
);
    localparam int TOT = DLY + HOLD;
    localparam int WW  = $clog2(WIN + 1);
    localparam int TW  = $clog2(TOT + 1);

    logic [WW-1:0] win_cnt;
    logic [TW-1:0] arm_cnt;

    // Unlock window: loaded by the unlock pattern, cancelled by any other guard write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (wr_en)
            win_cnt <= (wbits == 2'b11) ? WW'(WIN) : '0;
        else if (win_cnt != '0)
            win_cnt <= win_cnt - 1'b1;
    end

    // Arm countdown: loaded by an in-window arming write, then runs down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_cnt <= '0;
        else if (wr_en && wbits == 2'b10 && win_cnt != '0)
            arm_cnt <= TW'(TOT);
        else if (arm_cnt != '0)
            arm_cnt <= arm_cnt - 1'b1;
    end

    assign unlock_open = (win_cnt != '0);
    assign arm_set     = (arm_cnt != '0);
    assign arm_live    = (arm_cnt != '0) && (arm_cnt <= TW'(HOLD));
endmodule

// File: rtl/pwr_regs.sv
// Power control register: sleep enable and sleep mode.
// Assumes the top module has already decoded the write strobe for this register.
module pwr_regs
    import slpctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      se_in,
    input  logic [1:0] mode_in,
    output logic      se,
    output slp_mode_e mode
);
    // Register update: a write replaces both fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se   <= 1'b0;
            mode <= MODE_IDLE;
        end else if (wr_en) begin
            se   <= se_in;
            mode <= slp_mode_e'(mode_in);
        end
    end
endmodule

// File: rtl/sleep_fsm.sv
// Sleep state holder.
// Latches the brown-out and input-buffer decisions on sleep entry and keeps them
// until wake. Assumes wake has priority over a strobe on the same edge.
module sleep_fsm
    import slpctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_strobe,
    input  logic      wake,
    input  logic      se,
    input  slp_mode_e mode,
    input  logic      guard_live,
    output logic      asleep,
    output logic      bod_off,
    output logic      buf_off
);
    // Sleep entry and exit: the decisions are frozen while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep  <= 1'b0;
            bod_off <= 1'b0;
            buf_off <= 1'b0;
        end else if (wake) begin
            asleep  <= 1'b0;
            bod_off <= 1'b0;
            buf_off <= 1'b0;
        end else if (sleep_strobe && se && !asleep) begin
            asleep  <= 1'b1;
            bod_off <= guard_live;
            buf_off <= (mode == MODE_PDOWN);
        end
    end
endmodule

// File: rtl/sleep_power_ctrl.sv
// Top of the sleep power controller: register decode, readback, and submodules.
// Assumes at most one register write per cycle, and a single-cycle sleep strobe.
module sleep_power_ctrl
    import slpctl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 1,
    parameter int GUARD_ADR = 0,
    parameter int PWR_ADR   = 1,
    parameter int SE_BIT    = 5,
    parameter int MODE_LSB  = 3,
    parameter int WIN       = 4,
    parameter int DLY       = 3,
    parameter int HOLD      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_strobe,
    input  logic              wake,
    output logic              sleep_active,
    output logic              bod_enable,
    output logic              inbuf_disable
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'(3) | (DATA_W'(1) << SE_BIT) | (DATA_W'(3) << MODE_LSB);

    logic      guard_wr, pwr_wr;
    logic      unlock_open, arm_set, arm_live;
    logic      se_q;
    slp_mode_e mode_q;
    logic      bod_off, buf_off;
    logic      unused_wbits;

    assign guard_wr     = reg_we && (reg_addr == ADDR_W'(GUARD_ADR));
    assign pwr_wr       = reg_we && (reg_addr == ADDR_W'(PWR_ADR));
    assign unused_wbits = ^(reg_wdata & ~USED_MASK);

    bod_guard #(.WIN(WIN), .DLY(DLY), .HOLD(HOLD)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(guard_wr), .wbits(reg_wdata[1:0]),
        .unlock_open(unlock_open), .arm_set(arm_set), .arm_live(arm_live)
    );

    pwr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(pwr_wr),
        .se_in(reg_wdata[SE_BIT]), .mode_in(reg_wdata[MODE_LSB +: 2]),
        .se(se_q), .mode(mode_q)
    );

    sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .wake(wake),
        .se(se_q), .mode(mode_q), .guard_live(arm_live),
        .asleep(sleep_active), .bod_off(bod_off), .buf_off(buf_off)
    );

    // Readback multiplexer: unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(GUARD_ADR)) begin
            reg_rdata[1] = arm_set;
            reg_rdata[0] = unlock_open;
        end else if (reg_addr == ADDR_W'(PWR_ADR)) begin
            reg_rdata[SE_BIT]          = se_q;
            reg_rdata[MODE_LSB +: 2]   = mode_q;
        end
    end

    assign bod_enable    = !bod_off;
    assign inbuf_disable = buf_off;
endmodule

// File: rtl/sleep_power_ctrl_chk.sv
// Property checker for the sleep power controller, attached to it by bind.
// Assumes it sees the top-level ports and a few internal decision signals.
module sleep_power_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_strobe,
    input logic wake,
    input logic sleep_active,
    input logic bod_enable,
    input logic inbuf_disable,
    input logic se_q,
    input logic unlock_open,
    input logic arm_set,
    input logic arm_live
);
    // R8
    bod_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bod_enable |-> sleep_active);
    // R9
    buf_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inbuf_disable |-> sleep_active);
    // R10
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!sleep_active && bod_enable && !inbuf_disable));
    // R7
    no_se_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_strobe && !se_q && !sleep_active) |=> !sleep_active);
    // R8
    bod_off_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep_active) && !bod_enable) |-> $past(arm_live));
    // R4
    arm_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_set) |-> $past(unlock_open));
    // R11
    asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && !wake) |=> ($stable(bod_enable) && $stable(inbuf_disable)));
endmodule

bind sleep_power_ctrl sleep_power_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .wake(wake),
    .sleep_active(sleep_active), .bod_enable(bod_enable),
    .inbuf_disable(inbuf_disable), .se_q(se_q), .unlock_open(unlock_open),
    .arm_set(arm_set), .arm_live(arm_live)
);

// File: tb/sleep_power_ctrl_test.sv
module sleep_power_ctrl_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       sleep_strobe = 1'b0;
    logic       wake = 1'b0;
    logic       sleep_active, bod_enable, inbuf_disable;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    typedef struct {
        string      req;
        logic [10:0] exp;
    } item_t;
    item_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    sleep_power_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .sleep_strobe(sleep_strobe),
        .wake(wake), .sleep_active(sleep_active), .bod_enable(bod_enable),
        .inbuf_disable(inbuf_disable)
    );

    // Monitor: compares queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [10:0] got;
                it  = sb.pop_front();
                got = {sleep_active, bod_enable, inbuf_disable, reg_rdata};
                vectors++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got sa/be/ib/rd=%b/%b/%b/%h expected %b/%b/%b/%h",
                             it.req, got[10], got[9], got[8], got[7:0],
                             it.exp[10], it.exp[9], it.exp[8], it.exp[7:0]);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic w);
        sleep_strobe = s; wake = w;
        @(negedge clk);
        sleep_strobe = 1'b0; wake = 1'b0;
    endtask

    // Driver side of the scoreboard: selects the read address, queues the expectation.
    task automatic expect_st(input string req, input logic a, input logic sa,
                             input logic be, input logic ib, input logic [7:0] rd);
        item_t it;
        reg_addr = a;
        it.req = req;
        it.exp = {sa, be, ib, rd};
        sb.push_back(it);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        expect_st("R1 guard", 1'b0, 0, 1, 0, 8'h00);
        step();
        expect_st("R1 power", 1'b1, 0, 1, 0, 8'h00);
        step();

        // R2 register map masking
        wr(1'b1, 8'hFF);
        expect_st("R2 power mask", 1'b1, 0, 1, 0, 8'h38);
        step();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFC);
        expect_st("R2/R5 guard pattern 00", 1'b0, 0, 1, 0, 8'h00);
        step();

        // R3 unlock window lifetime
        wr(1'b0, 8'h03);
        expect_st("R3 unlock set", 1'b0, 0, 1, 0, 8'h01);
        repeat (3) step();
        expect_st("R3 unlock last cycle", 1'b0, 0, 1, 0, 8'h01);
        step();
        expect_st("R3 unlock expired", 1'b0, 0, 1, 0, 8'h00);
        repeat (6) step();

        // R4 arming inside and outside window
        wr(1'b0, 8'h03);
        repeat (3) step();
        wr(1'b0, 8'h02);
        expect_st("R4 arm on 4th edge", 1'b0, 0, 1, 0, 8'h02);
        repeat (7) step();
        wr(1'b0, 8'h03);
        repeat (4) step();
        wr(1'b0, 8'h02);
        expect_st("R4 arm on 5th edge refused", 1'b0, 0, 1, 0, 8'h00);
        step();
        wr(1'b0, 8'h02);
        expect_st("R4 arm without unlock", 1'b0, 0, 1, 0, 8'h00);
        step();

        // R5 cancellation by other pattern
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h01);
        expect_st("R5 pattern 01 cancels", 1'b0, 0, 1, 0, 8'h00);
        step();
        wr(1'b0, 8'h02);
        expect_st("R5 arm after cancel", 1'b0, 0, 1, 0, 8'h00);
        step();

        // R6 armed flag lifetime
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h02);
        for (int j = 0; j <= 6; j++) begin
            expect_st("R6 armed lifetime", 1'b0, 0, 1, 0, (j < 6) ? 8'h02 : 8'h00);
            step();
        end

        // R7 sleep enable gating
        wr(1'b1, 8'h10);
        pulse(1'b1, 1'b0);
        expect_st("R7 no sleep when disabled", 1'b1, 0, 1, 0, 8'h10);
        step();
        wr(1'b1, 8'h30);
        pulse(1'b1, 1'b0);
        expect_st("R7/R9 sleep power-down", 1'b1, 1, 1, 1, 8'h30);
        step();
        pulse(1'b0, 1'b1);
        expect_st("R10 wake", 1'b1, 0, 1, 0, 8'h30);
        step();

        // R8 guard live window edges
        for (int j = 2; j <= 6; j++) begin
            wr(1'b1, 8'h20);
            wr(1'b0, 8'h03);
            wr(1'b0, 8'h02);
            repeat (j) step();
            pulse(1'b1, 1'b0);
            expect_st("R8 bod decision", 1'b1, 1, (j < 3 || j > 5), 0, 8'h20);
            step();
            pulse(1'b0, 1'b1);
            expect_st("R10 wake after R8", 1'b1, 0, 1, 0, 8'h20);
            repeat (7) step();
        end

        // R9 modes other than power-down keep buffers on
        for (int m = 0; m < 4; m++) begin
            wr(1'b1, 8'h20 | 8'(m << 3));
            pulse(1'b1, 1'b0);
            expect_st("R9 mode buffers", 1'b1, 1, 1, (m == 2), 8'h20 | 8'(m << 3));
            step();
            pulse(1'b0, 1'b1);
        end

        // R10 wake beats a simultaneous strobe
        wr(1'b1, 8'h30);
        pulse(1'b1, 1'b1);
        expect_st("R10 wake wins", 1'b1, 0, 1, 0, 8'h30);
        step();

        // R11 strobes and writes while asleep are ignored
        wr(1'b1, 8'h20);
        pulse(1'b1, 1'b0);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h02);
        repeat (3) step();
        pulse(1'b1, 1'b0);
        expect_st("R11 strobe while asleep", 1'b1, 1, 1, 0, 8'h20);
        step();
        wr(1'b1, 8'h30);
        expect_st("R11 write while asleep", 1'b1, 1, 1, 0, 8'h30);
        step();
        pulse(1'b0, 1'b1);
        expect_st("R10 final wake", 1'b1, 0, 1, 0, 8'h30);
        step();
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule